// File: doc/BRIEF.md
# Serial-Loaded Latched Switch Control Register

This block drives a bank of on/off switch enables from a three-wire serial stream. On each rising edge of the serial clock, a bit enters the first stage of a shift register and every stage moves up by one place. The last stage appears on a serial output, so several of these blocks can be chained on one data line. Each switch enable comes from a per-bit output latch. The latch follows its register bit while the hold input is low. It keeps its value from the moment the hold input goes high. A clear input turns every switch off and takes priority over all other inputs.

All serial inputs are asynchronous to the system clock. They pass through a short synchronizer before they act on the state. The one exception is the clear input, which masks the switch outputs at once, with no clock involved. A host loads a new pattern with the hold input high, so the switches do not flicker while the bits move through. It then pulses the hold input low, and the switches take the new pattern together.

Top module: `serial_switch_latch`

## Requirements
- R1: Each rising edge of `ser_clk` moves `ser_din` into stage 0 and stage k into stage k+1. After eight edges, the first bit shifted in sits in stage 7 and drives `sw_on[7]`.
- R2: While `latch_hold` is low and clear is inactive, `sw_on` follows the shift register after every shift, within a few system clock cycles.
- R3: On a rising edge of `latch_hold`, the latches capture their value. While `latch_hold` stays high, further shifting leaves `sw_on` unchanged.
- R4: While `clr` is high, `sw_on` is all zero, from the moment `clr` rises. This holds whatever the state of `latch_hold` and the serial clock.
- R5: Clear does not alter the shift register. After `clr` falls with `latch_hold` high, `sw_on` stays all zero. When `latch_hold` next goes low, `sw_on` shows the register contents, including any bits shifted in during the clear.
- R6: `ser_dout` is 1 exactly when stage 7 of the shift register is 1.
- R7: Bit n of the register controls `sw_on[n]`, where 1 means on and 0 means off. Every bit pattern is reproduced, and the bits do not depend on one another.
- R8: During and after reset, every switch is off and the shift register holds zero, so `ser_dout` is 0.
- R9: Each bit is captured correctly when `ser_din` is set up at least 15 ns before and held at least 35 ns after the `ser_clk` rise, at up to 5 MHz. The hold and clear pulses last at least 150 ns. Data is stable at least 150 ns before `latch_hold` rises.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that samples the serial inputs |
| rst_n | input | 1 | Asynchronous active-low reset |
| ser_clk | input | 1 | Serial shift clock; data shifts on its rising edge |
| ser_din | input | 1 | Serial data into stage 0 |
| latch_hold | input | 1 | Low: latches transparent; high: latches hold |
| clr | input | 1 | Forces all switch enables off; overrides every other input |
| ser_dout | output | 1 | Copy of the last shift register stage, for chaining |
| sw_on | output | NUM_SW | Switch enables, 1 = on |

## Verification
On every cycle, the assertions check four things. Each serial edge moves data one stage and copies the old stage 6 to the serial output. The outputs track the register while transparent and do not move while held. Clear masks the outputs. The interface timing windows for setup, hold, pulse widths and setup before the hold input rises are respected. Other behaviours appear only at the ports over a whole sequence, so only the bench's scenarios can show them. These are the bit ordering after eight shifts, the capture of a pattern at the hold edge, and the register surviving a clear and reappearing on the next transparent phase.

// File: rtl/serial_switch_latch.sv
module serial_switch_latch #(
  parameter int NUM_SW      = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ser_clk,
  input  logic              ser_din,
  input  logic              latch_hold,
  input  logic              clr,
  output logic              ser_dout,
  output logic [NUM_SW-1:0] sw_on
);

  logic [SYNC_STAGES-1:0] clk_sync, din_sync, hold_sync, clr_sync;
  logic clk_s, din_s, hold_s, clr_s, clk_s_d, shift_evt;
  logic [NUM_SW-1:0] stage_q, stage_nxt, latch_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      clk_sync  <= '0;
      din_sync  <= '0;
      hold_sync <= '0;
      clr_sync  <= '0;
    end else begin
      clk_sync  <= {clk_sync[SYNC_STAGES-2:0], ser_clk};
      din_sync  <= {din_sync[SYNC_STAGES-2:0], ser_din};
      hold_sync <= {hold_sync[SYNC_STAGES-2:0], latch_hold};
      clr_sync  <= {clr_sync[SYNC_STAGES-2:0], clr};
    end
  end

  assign clk_s  = clk_sync[SYNC_STAGES-1];
  assign din_s  = din_sync[SYNC_STAGES-1];
  assign hold_s = hold_sync[SYNC_STAGES-1];
  assign clr_s  = clr_sync[SYNC_STAGES-1];

  assign shift_evt = clk_s & ~clk_s_d;
  assign stage_nxt = shift_evt ? {stage_q[NUM_SW-2:0], din_s} : stage_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      clk_s_d <= 1'b0;
      stage_q <= '0;
    end else begin
      clk_s_d <= clk_s;
      stage_q <= stage_nxt;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      latch_q <= '0;
    else if (clr_s)  latch_q <= '0;
    else if (!hold_s) latch_q <= stage_nxt;
  end

  assign sw_on    = clr ? '0 : latch_q;
  assign ser_dout = stage_q[NUM_SW-1];

endmodule

// File: rtl/serial_switch_latch_chk.sv
module serial_switch_latch_chk #(
  parameter int NUM_SW    = 8,
  parameter int SETUP_CYC = 2,
  parameter int HOLD_CYC  = 5,
  parameter int PULSE_CYC = 19,
  parameter int CNT_W     = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              ser_clk,
  input logic              ser_din,
  input logic              latch_hold,
  input logic              clr,
  input logic              ser_dout,
  input logic [NUM_SW-1:0] sw_on,
  input logic [NUM_SW-1:0] sr,
  input logic              din_s,
  input logic              hold_s,
  input logic              clr_s,
  input logic              shift_evt
);

  localparam logic [CNT_W-1:0] SAT     = '1;
  localparam logic [CNT_W-1:0] L_SETUP = CNT_W'(SETUP_CYC);
  localparam logic [CNT_W-1:0] L_HOLD  = CNT_W'(HOLD_CYC);
  localparam logic [CNT_W-1:0] L_PULSE = CNT_W'(PULSE_CYC);
  localparam logic [CNT_W-1:0] ONE     = CNT_W'(1);

  logic clk_d, din_d, hold_d, clr_d;
  logic [CNT_W-1:0] n_rise, n_din, n_hold, n_clr;

  function automatic logic [CNT_W-1:0] bump(input logic restart, input logic [CNT_W-1:0] v);
    if (restart)   return ONE;
    if (v == SAT)  return SAT;
    return v + ONE;
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      clk_d <= 1'b0; din_d <= 1'b0; hold_d <= 1'b0; clr_d <= 1'b0;
      n_rise <= SAT; n_din <= SAT; n_hold <= SAT; n_clr <= SAT;
    end else begin
      clk_d  <= ser_clk;
      din_d  <= ser_din;
      hold_d <= latch_hold;
      clr_d  <= clr;
      n_rise <= bump(ser_clk && !clk_d, n_rise);
      n_din  <= bump(ser_din != din_d, n_din);
      n_hold <= bump(latch_hold && !hold_d, n_hold);
      n_clr  <= bump(clr && !clr_d, n_clr);
    end
  end

  p_shift_in_r1: assert property (@(posedge clk) disable iff (!rst_n)
    shift_evt |=> sr[0] == $past(din_s));

  p_dout_advance_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $past(shift_evt) |-> ser_dout == $past(sr[NUM_SW-2]));

  p_transparent_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (!hold_s && !clr_s && !clr) |=> (clr || sw_on == sr));

  p_hold_stable_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (hold_s && !clr_s && !clr) |=> (clr || clr_s || $stable(sw_on)));

  p_clear_off_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (clr || clr_s) |-> sw_on == '0);

  p_clear_release_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (hold_s && $past(hold_s) && $past(clr_s)) |-> sw_on == '0);

  p_din_setup_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (ser_clk && !clk_d) |-> n_din >= L_SETUP);

  p_din_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (ser_din != din_d) |-> n_rise >= L_HOLD);

  p_hold_setup_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (latch_hold && !hold_d) |-> n_din >= L_PULSE);

  p_hold_width_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (!latch_hold && hold_d) |-> n_hold >= L_PULSE);

  p_clr_width_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (!clr && clr_d) |-> n_clr >= L_PULSE);

  always @(posedge clk) begin
    if (!rst_n) begin
      p_reset_state_r8: assert (sw_on == '0 && sr == '0 && ser_dout == 1'b0);
    end
  end

endmodule

bind serial_switch_latch serial_switch_latch_chk #(.NUM_SW(NUM_SW)) u_chk (
  .clk(clk), .rst_n(rst_n), .ser_clk(ser_clk), .ser_din(ser_din),
  .latch_hold(latch_hold), .clr(clr), .ser_dout(ser_dout), .sw_on(sw_on),
  .sr(stage_q), .din_s(din_s), .hold_s(hold_s), .clr_s(clr_s),
  .shift_evt(shift_evt)
);

// File: tb/serial_switch_latch_bench.sv
`timescale 1ns/1ps
module serial_switch_latch_bench;

  logic clk = 1'b0, rst_n = 1'b0;
  logic ser_clk = 1'b0, ser_din = 1'b0, latch_hold = 1'b0, clr = 1'b0;
  logic ser_dout;
  logic [7:0] sw_on;
  int checks = 0, fails = 0;
  bit done = 1'b0;

  serial_switch_latch #(.NUM_SW(8), .SYNC_STAGES(2)) u_serial_switch_latch (
    .clk(clk), .rst_n(rst_n), .ser_clk(ser_clk), .ser_din(ser_din),
    .latch_hold(latch_hold), .clr(clr), .ser_dout(ser_dout), .sw_on(sw_on)
  );

  always #4 clk = ~clk;

  // {hold while shifting, pattern, expected switches}
  localparam logic [16:0] VEC [8] = '{
    17'h0A5A5, 17'h03C3C, 17'h1FF3C, 17'h00000,
    17'h18100, 17'h08181, 17'h0FFFF, 17'h15AFF
  };

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic shift_bit(input logic b, input int su, input int ho);
    ser_din = b;
    cyc(su);
    ser_clk = 1'b1;
    cyc(ho);
    if (ho < 12) ser_din = ~b;
    cyc(12 - ho);
    ser_clk = 1'b0;
    cyc(13 - su);
  endtask

  task automatic shift_byte(input logic [7:0] p, input int su, input int ho);
    for (int i = 7; i >= 0; i--) shift_bit(p[i], su, ho);
  endtask

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      summary();
      $finish;
    end
  end

  initial begin
    cyc(5);
    check("R8 reset switches off", sw_on, 8'h00);
    check("R8 reset dout", {7'b0, ser_dout}, 8'h00);
    rst_n = 1'b1;
    cyc(10);
    check("R8 register zero after reset", sw_on, 8'h00);

    for (int v = 0; v < 8; v++) begin
      cyc(25);
      latch_hold = VEC[v][16];
      cyc(25);
      shift_byte(VEC[v][15:8], 13, 12);
      cyc(10);
      check(VEC[v][16] ? "R3 held during shift" : "R2/R7 transparent pattern", sw_on, VEC[v][7:0]);
      check("R6 dout is stage 7", {7'b0, ser_dout}, {7'b0, VEC[v][15]});
      if (VEC[v][16]) begin
        latch_hold = 1'b0;
        cyc(10);
        check("R2 release shows register", sw_on, VEC[v][15:8]);
      end
    end

    shift_byte(8'h00, 13, 12);
    shift_bit(1'b1, 13, 12);
    cyc(5);
    check("R1 first bit in stage 0", sw_on, 8'h01);
    for (int i = 0; i < 7; i++) shift_bit(1'b0, 13, 12);
    cyc(5);
    check("R1 first bit reaches switch 7", sw_on, 8'h80);
    check("R6 dout high with stage 7", {7'b0, ser_dout}, 8'h01);

    cyc(25);
    shift_byte(8'h6B, 2, 5);
    cyc(10);
    check("R9 minimum setup and hold", sw_on, 8'h6B);

    cyc(25);
    latch_hold = 1'b1;
    cyc(25);
    shift_byte(8'h00, 13, 12);
    cyc(10);
    check("R3 captured at hold edge", sw_on, 8'h6B);
    latch_hold = 1'b0;
    cyc(10);
    check("R3 new pattern after release", sw_on, 8'h00);

    shift_byte(8'hC3, 13, 12);
    cyc(10);
    check("R7 pattern C3", sw_on, 8'hC3);
    clr = 1'b1;
    #1;
    check("R4 clear acts at once", sw_on, 8'h00);
    cyc(1);
    shift_bit(1'b1, 13, 12);
    cyc(10);
    check("R4 clear overrides transparent shift", sw_on, 8'h00);
    cyc(25);
    latch_hold = 1'b1;
    cyc(25);
    clr = 1'b0;
    cyc(10);
    check("R5 off after clear while held", sw_on, 8'h00);
    check("R5 register kept through clear", {7'b0, ser_dout}, 8'h01);
    latch_hold = 1'b0;
    cyc(10);
    check("R5 register shown after release", sw_on, 8'h87);

    cyc(10);
    done = 1'b1;
    summary();
    $finish;
  end

endmodule